// File: doc/BRIEF.md
# Mirror Detect Signal Generator

This block turns a stream of digitised optical-disc RF envelope samples into a mirror flag. It keeps two running hold values: a peak hold that follows the highest sample and a bottom hold that follows the lowest. Their difference is the envelope amplitude, which is compared with a comparator level supplied from outside. The flag is raised only after that comparison has been true at a programmable number of consecutive clock edges. A single edge on which it fails drops the flag again.

Both hold values drift back toward the current sample on a periodic step tick. The peak hold drifts down by one LSB per tick. The bottom hold climbs by a programmable number of LSBs per tick and never rises past the sample. A replace control lets an externally generated zero-cross flag drive the output in place of the internal result.

Samples enter through a strobe-qualified port. All control fields are static inputs and are sampled every clock.

Top module: `mirr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets `mirr_out` to 0, the peak hold to 0, the bottom hold to full scale and the captured sample to 0.
- R2: `smp_data` is captured only on edges where `smp_valid` is 1; a changed `smp_data` with `smp_valid` at 0 has no effect on `mirr_out`.
- R3: The comparison is true when peak hold > bottom hold and (peak hold − bottom hold) ≥ `cmp_level`.
- R4: `mirr_out` becomes 1 at the edge that is the Nth consecutive edge with a true comparison. N = `MASK_BASE << mask_sel`: 00→1×, 01→2×, 10→4×, 11→8× `MASK_BASE`. The default `MASK_BASE` = 32 gives about 5.67 µs at 5.6448 MHz.
- R5: An edge at which the comparison is false clears the qualification count and sets `mirr_out` to 0 at that same edge (replace off).
- R6: A captured sample above the peak hold loads it at the next edge. Otherwise, on a step tick, a peak hold above the sample decreases by exactly 1.
- R7: A captured sample below the bottom hold loads it at the next edge. Otherwise, on a step tick, the bottom hold increases by `1 << step_sel` (00→1, 01→2, 10→4, 11→8), clamped to the captured sample.
- R8: While `hold_mode` is 1, `step_sel` is ignored and the bottom hold climbs by 1 per tick.
- R9: The step tick is a one-cycle pulse every `STEP_CYC` clocks; the default of 4 is about 708 ns at 5.6448 MHz.
- R10: While `replace_en` is 1, `mirr_out` takes the value `zc_flag` had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | W | Envelope sample, unsigned |
| cmp_level | input | W | Mirror comparator level |
| mask_sel | input | 2 | Minimum continuous-compare time select |
| step_sel | input | 2 | Bottom-hold steps per tick select |
| hold_mode | input | 1 | 1 forces a single step per tick |
| replace_en | input | 1 | 1 routes `zc_flag` to the output |
| zc_flag | input | 1 | External zero-cross flag |
| mirr_out | output | 1 | Registered mirror flag |

## Verification
The bench builds the block with `W` = 8, `STEP_CYC` = 4 and `MASK_BASE` = 8. With these values all four qualification windows (8 to 64 edges) and a full bottom-hold climb at every step setting each finish within a few hundred cycles. Qualification timing is checked to the exact edge. Drift rates are read from how long `mirr_out` stays high while the amplitude crosses the level. Those windows are far enough apart to tell each step setting apart, despite the free-running tick phase.

// File: rtl/mirr_pkg.sv
package mirr_pkg;

  // Bottom-hold LSBs added per step tick for a given select code.
  function automatic int unsigned step_count(input logic [1:0] sel);
    return 32'd1 << sel;
  endfunction

  // Consecutive true-compare edges required before the flag rises.
  function automatic int unsigned qual_edges(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

endpackage

// File: rtl/mirr_step_timer.sv
module mirr_step_timer #(
  parameter int STEP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mirr_hold_track.sv
module mirr_hold_track #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  samp,
  input  logic          tick,
  input  logic [SW-1:0] step_amt,
  output logic [W-1:0]  peak,
  output logic [W-1:0]  bot
);
  // One guard bit so the climbing bottom hold cannot wrap before the clamp.
  logic [W:0] creep;
  assign creep = {1'b0, bot} + {{(W + 1 - SW){1'b0}}, step_amt};

  always_ff @(posedge clk) begin
    if (rst) begin
      peak <= '0;
      bot  <= '1;
    end else begin
      if (samp > peak)
        peak <= samp;
      else if (tick && (peak > samp))
        peak <= peak - 1'b1;

      if (samp < bot)
        bot <= samp;
      else if (tick)
        bot <= (creep > {1'b0, samp}) ? samp : creep[W-1:0];
    end
  end
endmodule

// File: rtl/mirr_qualifier.sv
module mirr_qualifier
  import mirr_pkg::*;
#(
  parameter int W         = 8,
  parameter int MASK_BASE = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] peak,
  input  logic [W-1:0] bot,
  input  logic [W-1:0] level,
  input  logic [1:0]   mask_sel,
  output logic         cmp_true,
  output logic         qual_hit
);
  localparam int MAXN = MASK_BASE * 8;
  localparam int CW   = (MAXN > 1) ? $clog2(MAXN) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic [W-1:0]  amp;

  assign lim_m1   = CW'(qual_edges(MASK_BASE, mask_sel) - 1);
  assign amp      = peak - bot;
  assign cmp_true = (peak > bot) && (amp >= level);
  assign qual_hit = cmp_true && (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst || !cmp_true)
      cnt <= '0;
    else if (cnt < lim_m1)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mirr_gen.sv
module mirr_gen
  import mirr_pkg::*;
#(
  parameter int W         = 8,
  parameter int STEP_CYC  = 4,
  parameter int MASK_BASE = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_data,
  input  logic [W-1:0] cmp_level,
  input  logic [1:0]   mask_sel,
  input  logic [1:0]   step_sel,
  input  logic         hold_mode,
  input  logic         replace_en,
  input  logic         zc_flag,
  output logic         mirr_out
);
  localparam int SW = 4;

  logic [W-1:0]  samp_q;
  logic [W-1:0]  peak_q;
  logic [W-1:0]  bot_q;
  logic [SW-1:0] step_amt;
  logic          step_tick;
  logic          cmp_true;
  logic          qual_hit;

  always_ff @(posedge clk) begin
    if (rst)
      samp_q <= '0;
    else if (smp_valid)
      samp_q <= smp_data;
  end

  assign step_amt = hold_mode ? SW'(1) : SW'(step_count(step_sel));

  mirr_step_timer #(.STEP_CYC(STEP_CYC)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .tick (step_tick)
  );

  mirr_hold_track #(.W(W), .SW(SW)) track_i (
    .clk      (clk),
    .rst      (rst),
    .samp     (samp_q),
    .tick     (step_tick),
    .step_amt (step_amt),
    .peak     (peak_q),
    .bot      (bot_q)
  );

  mirr_qualifier #(.W(W), .MASK_BASE(MASK_BASE)) qual_i (
    .clk      (clk),
    .rst      (rst),
    .peak     (peak_q),
    .bot      (bot_q),
    .level    (cmp_level),
    .mask_sel (mask_sel),
    .cmp_true (cmp_true),
    .qual_hit (qual_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)
      mirr_out <= 1'b0;
    else
      mirr_out <= replace_en ? zc_flag : qual_hit;
  end
endmodule

// File: rtl/mirr_gen_chk.sv
module mirr_gen_chk #(
  parameter int W         = 8,
  parameter int MASK_BASE = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] samp_q,
  input logic [W-1:0] peak,
  input logic [W-1:0] bot,
  input logic         tick,
  input logic [W-1:0] cmp_level,
  input logic [1:0]   mask_sel,
  input logic         replace_en,
  input logic         zc_flag,
  input logic         mirr_out
);
  localparam int RW = $clog2(MASK_BASE * 8 + 2);

  logic          cmp_c;
  logic [RW-1:0] run;

  assign cmp_c = (peak > bot) && ((peak - bot) >= cmp_level);

  // Independent count of consecutive true-compare edges.
  always_ff @(posedge clk) begin
    if (rst || !cmp_c)
      run <= '0;
    else if (run != '1)
      run <= run + 1'b1;
  end

  p_rise_after_run_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(mirr_out) && !$past(replace_en)) |-> (32'(run) >= (MASK_BASE << $past(mask_sel))));

  p_drop_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (!replace_en && !cmp_c) |=> !mirr_out);

  p_peak_not_below_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (peak >= $past(samp_q)));

  p_peak_decay_one_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((peak >= $past(peak)) || (peak == $past(peak) - 1'b1)));

  p_bot_clamped_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bot <= $past(samp_q)));

  p_tick_single_r9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_replace_path_r10: assert property (@(posedge clk) disable iff (rst)
    replace_en |=> (mirr_out == $past(zc_flag)));
endmodule

bind mirr_gen mirr_gen_chk #(.W(W), .MASK_BASE(MASK_BASE)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .samp_q     (samp_q),
  .peak       (peak_q),
  .bot        (bot_q),
  .tick       (step_tick),
  .cmp_level  (cmp_level),
  .mask_sel   (mask_sel),
  .replace_en (replace_en),
  .zc_flag    (zc_flag),
  .mirr_out   (mirr_out)
);

// File: tb/mirr_gen_tb.sv
module mirr_gen_tb_top;
  localparam int W  = 8;
  localparam int SC = 4;
  localparam int MB = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_valid = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic [W-1:0] cmp_level = '1;
  logic [1:0]   mask_sel = 2'd0;
  logic [1:0]   step_sel = 2'd0;
  logic         hold_mode = 1'b0;
  logic         replace_en = 1'b0;
  logic         zc_flag = 1'b0;
  logic         mirr_out;

  always #10 clk = ~clk;

  mirr_gen #(.W(W), .STEP_CYC(SC), .MASK_BASE(MB)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .cmp_level(cmp_level), .mask_sel(mask_sel), .step_sel(step_sel),
    .hold_mode(hold_mode), .replace_en(replace_en), .zc_flag(zc_flag),
    .mirr_out(mirr_out)
  );

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic note(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_at(input int due, input logic v, input string tag);
    exp_t e;
    e.due = due; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares scoreboard items when their cycle comes due.
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        e = q.pop_front();
        note(mirr_out === e.val, e.tag, int'(mirr_out), int'(e.val));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic drive_sample(input logic [W-1:0] v);
    smp_data = v; smp_valid = 1'b1;
    step(1);
    smp_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [W-1:0] lvl);
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0; smp_data = '0; cmp_level = lvl;
    mask_sel = 2'd0; step_sel = 2'd3; hold_mode = 1'b0;
    replace_en = 1'b0; zc_flag = 1'b0;
    step(2);
    rst = 1'b0;
    expect_at(cyc + 1, 1'b0, "R1 reset state");
  endtask

  // Peak and bottom both settle at 200, flag low, level 100.
  task automatic prep();
    do_reset(8'd100);
    drive_sample(8'd200);
    step(130);
    drain();
  endtask

  task automatic mask_test(input logic [1:0] sel);
    int c;
    int n;
    prep();
    mask_sel = sel;
    n = MB << sel;
    if (sel == 2'd0) begin
      smp_data = 8'd40;
      expect_at(cyc + 10, 1'b0, "R2 data ignored without strobe");
      expect_at(cyc + 20, 1'b0, "R2 data ignored without strobe");
      step(20);
      drain();
    end
    c = cyc;
    drive_sample(8'd40);
    expect_at(c + n + 1, 1'b0, $sformatf("R4 mask=%0d not yet high", sel));
    expect_at(c + n + 2, 1'b1, $sformatf("R4 mask=%0d rises", sel));
    drain();
  endtask

  // Returns cycles from the call until the flag falls after having been high.
  task automatic measure_fall(input int t0, output int dur, output bit seen);
    seen = 1'b0;
    dur = -1;
    for (int i = 0; i < 600; i++) begin
      step(1);
      if (mirr_out) seen = 1'b1;
      else if (seen) begin
        dur = cyc - t0;
        break;
      end
    end
  endtask

  task automatic creep_test(input logic [1:0] sel, input logic hm, input int ticks, input string tag);
    int  t1;
    int  dur;
    bit  seen;
    prep();
    step_sel = sel;
    hold_mode = hm;
    drive_sample(8'd40);
    t1 = cyc;
    drive_sample(8'd200);
    measure_fall(t1, dur, seen);
    note(seen && dur >= 4 * ticks - 4 && dur <= 4 * ticks + 6, tag, dur, 4 * ticks);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int c;
    int dur;
    bit seen;

    // R4 qualification windows; R2 tested inside the first one
    for (int s = 0; s < 4; s++) mask_test(2'(s));

    // R5 interruption restarts the count, then a miss drops the flag
    prep();
    c = cyc;
    drive_sample(8'd40);
    step(3);
    cmp_level = 8'd255;
    step(1);
    cmp_level = 8'd100;
    expect_at(c + 12, 1'b0, "R5 count restarted after miss");
    expect_at(c + 13, 1'b1, "R5 rises after fresh window");
    drain();
    step(4);
    expect_at(cyc + 1, 1'b1, "R5 still high before miss");
    expect_at(cyc + 2, 1'b0, "R5 drops on first miss");
    step(1);
    cmp_level = 8'd255;
    step(2);
    drain();

    // R10 replace path with internal flag low, then high
    do_reset(8'd255);
    step(2);
    replace_en = 1'b1; zc_flag = 1'b1;
    expect_at(cyc + 1, 1'b1, "R10 zero-cross high routed");
    step(1);
    zc_flag = 1'b0;
    expect_at(cyc + 1, 1'b0, "R10 zero-cross low routed");
    step(2);
    drain();
    prep();
    drive_sample(8'd40);
    step(20);
    replace_en = 1'b1; zc_flag = 1'b0;
    expect_at(cyc + 1, 1'b0, "R10 overrides high internal flag");
    step(1);
    replace_en = 1'b0;
    expect_at(cyc + 1, 1'b1, "R10 internal flag restored");
    step(2);
    drain();

    // R7 R9 bottom climb rate per select: ceil(61/k) ticks of 4 clocks
    creep_test(2'd0, 1'b0, 61, "R7 R9 climb k=1");
    creep_test(2'd1, 1'b0, 31, "R7 R9 climb k=2");
    creep_test(2'd2, 1'b0, 16, "R7 R9 climb k=4");
    creep_test(2'd3, 1'b0, 8,  "R7 R9 climb k=8");
    // R8 hold_mode forces single steps despite step_sel=11
    creep_test(2'd3, 1'b1, 61, "R8 hold mode single step");

    // R6 peak decays 1 per tick (200 -> 189 in 11 ticks); R7 clamp keeps bottom at 40; R3 level 150
    prep();
    cmp_level = 8'd150;
    c = cyc;
    drive_sample(8'd40);
    measure_fall(c, dur, seen);
    note(seen && dur >= 38 && dur <= 52, "R6 R7 R3 peak decay with clamped bottom", dur, 44);

    step(2);
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule